// File: doc/BRIEF.md
# Dual-Read Register File with Hard-Wired Zero Register

This block stores eight 32-bit words for a small processor datapath. Each cycle, two operands can be read at the same time through independent read ports, and one result can be written back. Index 0 is a constant-zero source. Writes to index 0 are dropped, so software can use that index as a discard target. A separate debug output always shows word 2, so a test harness can watch one result register without using a read port.

Reads are purely combinational from the stored state. A write is captured on the rising clock edge. A read of the address being written therefore returns the old contents until that edge. An active-low asynchronous reset clears every stored word.

Top module: `tri_port_regfile`

## Requirements
- R1: The file holds 8 independent 32-bit words selected by a 3-bit address. A distinct value written to each of indices 1 to 7 reads back unchanged.
- R2: When wr_en_i is 1 and wr_addr_i is not 0, wr_data_i is stored at wr_addr_i on the rising edge of clk_i. The value is visible on the read ports from the cycle after that edge.
- R3: When wr_en_i is 0, no stored word changes across a clock edge, whatever is on wr_addr_i and wr_data_i.
- R4: Reads are combinational. A read of an address that is being written in the same cycle returns the previous contents until the clock edge.
- R5: The two read ports are independent. Each returns the word at its own address in the same cycle, including when both ports use the same address.
- R6: Index 0 reads as 0 on both ports at all times. A write with wr_en_i=1 and wr_addr_i=0 has no effect.
- R7: dbg_o always equals the contents of index 2. It follows a write to index 2 from the cycle after the clock edge, and no other write changes it.
- R8: While rst_ni is 0, all words read as 0 at once, without waiting for a clock edge. The words stay 0 after rst_ni returns to 1 until they are written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; writes are captured on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low clear of all words |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | 3 | Write address; index 0 is ignored |
| wr_data_i | input | 32 | Write data |
| rd_a_addr_i | input | 3 | Read port A address |
| rd_a_data_o | output | 32 | Read port A data, combinational |
| rd_b_addr_i | input | 3 | Read port B address |
| rd_b_data_o | output | 32 | Read port B data, combinational |
| dbg_o | output | 32 | Continuous copy of word 2 |

## Verification
Read data and dbg_o depend on the current addresses and the stored state with zero cycle latency. A write becomes visible exactly one rising edge after it is presented, and reset acts immediately. The bench applies each stimulus just after a falling edge and samples the outputs 1 ns later, before the next rising edge. It compares them against a model holding the pre-edge contents, which confirms the old-value-until-edge rule. The model is updated only at the rising edge. Reset is asserted in mid-cycle and checked before any edge arrives, which separates its asynchronous action from a clocked one.

// File: rtl/tri_port_regfile_pkg.sv
package tri_port_regfile_pkg;
  localparam int unsigned RF_DATA_W  = 32;
  localparam int unsigned RF_ADDR_W  = 3;
  localparam int unsigned RF_DBG_IDX = 2;
endpackage

// File: rtl/rf_wr_decode.sv
module rf_wr_decode #(
  parameter int unsigned ADDR_W = 3,
  localparam int unsigned NUM_REGS = 1 << ADDR_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  output logic [NUM_REGS-1:0] strobe_o
);
  // index 0 never receives a strobe
  assign strobe_o[0] = 1'b0;

  for (genvar i = 1; i < NUM_REGS; i++) begin : g_strobe
    assign strobe_o[i] = wr_en_i && (wr_addr_i == ADDR_W'(i));
  end

  p_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(strobe_o));

  p_strobe_needs_en_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |-> (strobe_o == '0));
endmodule

// File: rtl/rf_word.sv
module rf_word #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= d_i;
  end

  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> (q_o == $past(d_i)));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(q_o));
endmodule

// File: rtl/rf_rd_mux.sv
module rf_rd_mux #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 3,
  localparam int unsigned NUM_REGS = 1 << ADDR_W
) (
  input  logic [NUM_REGS-1:0][DATA_W-1:0] words_i,
  input  logic [ADDR_W-1:0]               addr_i,
  output logic [DATA_W-1:0]               data_o
);
  assign data_o = words_i[addr_i];
endmodule

// File: rtl/tri_port_regfile.sv
module tri_port_regfile
  import tri_port_regfile_pkg::*;
#(
  parameter int unsigned DATA_W  = RF_DATA_W,
  parameter int unsigned ADDR_W  = RF_ADDR_W,
  parameter int unsigned DBG_IDX = RF_DBG_IDX,
  localparam int unsigned NUM_REGS = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_a_addr_i,
  output logic [DATA_W-1:0] rd_a_data_o,
  input  logic [ADDR_W-1:0] rd_b_addr_i,
  output logic [DATA_W-1:0] rd_b_data_o,
  output logic [DATA_W-1:0] dbg_o
);
  logic [NUM_REGS-1:0]             strobe;
  logic [NUM_REGS-1:0][DATA_W-1:0] word_q;

  rf_wr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .strobe_o (strobe)
  );

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
    if (i == 0) begin : g_zero
      assign word_q[i] = '0;
    end else begin : g_store
      rf_word #(.DATA_W(DATA_W)) u_word (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .en_i  (strobe[i]),
        .d_i   (wr_data_i),
        .q_o   (word_q[i])
      );
    end
  end

  rf_rd_mux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd_a (
    .words_i(word_q),
    .addr_i (rd_a_addr_i),
    .data_o (rd_a_data_o)
  );

  rf_rd_mux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd_b (
    .words_i(word_q),
    .addr_i (rd_b_addr_i),
    .data_o (rd_b_data_o)
  );

  assign dbg_o = word_q[DBG_IDX];

  p_write_lands_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i != '0) |=> (word_q[$past(wr_addr_i)] == $past(wr_data_i)));

  p_no_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(word_q));

  p_no_zero_strobe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe[0]);

  p_zero_a_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_a_addr_i == '0) |-> (rd_a_data_o == '0));

  p_zero_b_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_b_addr_i == '0) |-> (rd_b_data_o == '0));

  p_dbg_follows_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == ADDR_W'(DBG_IDX)) |=> (dbg_o == $past(wr_data_i)));

  p_dbg_steady_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_addr_i == ADDR_W'(DBG_IDX)) |=> $stable(dbg_o));
endmodule

// File: tb/tri_port_regfile_bench.sv
module tri_port_regfile_bench;
  typedef struct packed {
    logic        we;
    logic [2:0]  wa;
    logic [31:0] wd;
    logic [2:0]  ra;
    logic [2:0]  rb;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 3'd1, 32'h1111_1111, 3'd0, 3'd0},
    '{1'b1, 3'd2, 32'h2222_2222, 3'd1, 3'd2},
    '{1'b1, 3'd3, 32'hA5A5_A5A5, 3'd2, 3'd1},
    '{1'b1, 3'd0, 32'hDEAD_BEEF, 3'd3, 3'd0},
    '{1'b0, 3'd4, 32'hFFFF_FFFF, 3'd0, 3'd3},
    '{1'b1, 3'd4, 32'h8000_0001, 3'd4, 3'd4},
    '{1'b1, 3'd5, 32'h0F0F_0F0F, 3'd4, 3'd0},
    '{1'b1, 3'd6, 32'hFEDC_BA98, 3'd5, 3'd6},
    '{1'b1, 3'd7, 32'h1357_9BDF, 3'd6, 3'd5},
    '{1'b1, 3'd2, 32'hCAFE_F00D, 3'd7, 3'd2},
    '{1'b0, 3'd2, 32'h0000_0000, 3'd2, 3'd7},
    '{1'b1, 3'd1, 32'h0000_0000, 3'd1, 3'd1},
    '{1'b0, 3'd0, 32'h0000_0000, 3'd0, 3'd2}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [2:0]  rd_a_addr_i = '0;
  logic [2:0]  rd_b_addr_i = '0;
  logic [31:0] rd_a_data_o, rd_b_data_o, dbg_o;

  logic [31:0] model [8];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  tri_port_regfile u_tri_port_regfile (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rd_a_addr_i(rd_a_addr_i), .rd_a_data_o(rd_a_data_o),
    .rd_b_addr_i(rd_b_addr_i), .rd_b_data_o(rd_b_data_o), .dbg_o(dbg_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // present inputs after a falling edge, check pre-edge reads, then take the edge
  task automatic step(input vec_t v, input string req);
    @(negedge clk_i);
    wr_en_i = v.we; wr_addr_i = v.wa; wr_data_i = v.wd;
    rd_a_addr_i = v.ra; rd_b_addr_i = v.rb;
    #1;
    chk({req, " port A"}, rd_a_data_o, model[v.ra]);
    chk({req, " port B"}, rd_b_data_o, model[v.rb]);
    chk("R7 debug", dbg_o, model[2]);
    @(posedge clk_i);
    if (v.we && v.wa != 3'd0) model[v.wa] = v.wd;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = '0;
    #10;
    // R8: reset state on both ports
    for (int i = 0; i < 8; i++) begin
      rd_a_addr_i = 3'(i); rd_b_addr_i = 3'(7 - i); #1;
      chk("R8 reset A", rd_a_data_o, 32'h0);
      chk("R8 reset B", rd_b_data_o, 32'h0);
    end
    @(negedge clk_i); rst_ni = 1'b1;

    // table walk: R2 R4 R5 R6 R7
    for (int k = 0; k < NV; k++) step(VECS[k], "R2/R4/R5");

    // R1: fill 1..7 with distinct values, read each back
    for (int i = 1; i < 8; i++) step('{1'b1, 3'(i), 32'h5A00_0000 + 32'(i * 257), 3'd0, 3'd0}, "R1 fill");
    for (int i = 1; i < 8; i++) step('{1'b0, 3'd0, 32'h0, 3'(i), 3'(8 - i)}, "R1 readback");

    // R3: enable low with live address and data
    step('{1'b0, 3'd5, 32'hBAD0_BAD0, 3'd5, 3'd2}, "R3 setup");
    step('{1'b0, 3'd2, 32'hBAD1_BAD1, 3'd5, 3'd2}, "R3 hold");
    step('{1'b0, 3'd0, 32'h0, 3'd5, 3'd2}, "R3 after");

    // R6: write to index 0 then read it on both ports
    step('{1'b1, 3'd0, 32'hFFFF_FFFF, 3'd0, 3'd0}, "R6 write");
    @(negedge clk_i); wr_en_i = 1'b0; rd_a_addr_i = 3'd0; rd_b_addr_i = 3'd0; #1;
    chk("R6 zero A", rd_a_data_o, 32'h0);
    chk("R6 zero B", rd_b_data_o, 32'h0);

    // R7: debug tracks a write to index 2 only after the edge
    @(negedge clk_i); wr_en_i = 1'b1; wr_addr_i = 3'd2; wr_data_i = 32'h7777_0002; #1;
    chk("R7 before edge", dbg_o, model[2]);
    @(negedge clk_i); wr_en_i = 1'b0; #1;
    chk("R7 after edge", dbg_o, 32'h7777_0002);
    model[2] = 32'h7777_0002;

    // R8: mid-cycle reset clears at once, stays clear after release
    @(negedge clk_i); rd_a_addr_i = 3'd7; rd_b_addr_i = 3'd3; #1;
    rst_ni = 1'b0; #1;
    chk("R8 async A", rd_a_data_o, 32'h0);
    chk("R8 async B", rd_b_data_o, 32'h0);
    chk("R8 async debug", dbg_o, 32'h0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i); #1;
    chk("R8 after release", rd_a_data_o, 32'h0);
    chk("R8 debug after release", dbg_o, 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule